// File: doc/BRIEF.md
# AXI-Lite Data Width Down-Converter

This block joins a wide AXI-Lite requester to a narrower AXI-Lite completer. It is used where a 32-bit or 64-bit register bus has to reach peripherals with a 16-bit, 8-bit or 32-bit data path. Every wide access turns into a short run of narrow accesses. These go out one after another at rising byte addresses, starting with the lowest data lane.

On a write, the block first accepts the wide address and the wide data, in either order. It then sends one narrow write for each lane that has at least one byte enabled, carrying that lane's bytes and byte enables. Lanes with no enabled bytes cost no bus cycles. On a read, a narrow read goes out for every lane, and each returned word is placed in its lane of the wide result. Only after the last narrow response does the requester get its single response. That response is OKAY if all parts succeeded, and otherwise the most severe error seen. The write side and the read side each handle one wide access at a time.

Top module: `axil_downsizer`

## Requirements
- R1: A wide read produces exactly WIDE_DW/NARROW_DW narrow reads. A wide write produces one narrow write per lane whose byte enables are not all zero, and never more than WIDE_DW/NARROW_DW.
- R2: Narrow accesses go out in ascending lane order. Lane k uses address base + k*(NARROW_DW/8), so with the defaults lane 0 is at base and lane 1 at base+2.
- R3: The narrow write for lane k carries wide data bits [k*NARROW_DW +: NARROW_DW] and wide byte enable bits [k*NARROW_DW/8 +: NARROW_DW/8]. For example, enables 4'b1011 give 2'b11 for lane 0 and 2'b10 for lane 1.
- R4: A lane whose byte enables are all zero is never sent. A wide write with all enables zero sends no narrow write and still returns one OKAY (2'b00) response.
- R5: The narrow read data of lane k appears in wide read data bits [k*NARROW_DW +: NARROW_DW].
- R6: The wide response is 2'b00 when every narrow response is 2'b00. Otherwise it is the numerically largest code returned (SLVERR 2'b10, DECERR 2'b11). Lanes after a failing lane are still sent, and a lane that was skipped contributes no code.
- R7: The wide write or read response is raised only after the last narrow response handshake of that access. While it is raised, no narrow request or response acceptance is pending on that side.
- R8: Both the wide address and the wide write data are accepted before any narrow write starts. For each lane, the narrow address and narrow data become valid in the same cycle.
- R9: While a wide write is in progress, the wide write address and write data ready outputs stay low. While a wide read is in progress, the wide read address ready stays low.
- R10: During reset, every valid output on both sides is low.
- R11: Once a narrow address or narrow write data is offered, it stays valid and unchanged until the completer accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_awvalid | input | 1 | Wide write address valid |
| s_awready | output | 1 | Wide write address ready |
| s_awaddr | input | ADDR_W | Wide write byte address |
| s_wvalid | input | 1 | Wide write data valid |
| s_wready | output | 1 | Wide write data ready |
| s_wdata | input | WIDE_DW | Wide write data |
| s_wstrb | input | WIDE_DW/8 | Wide byte enables |
| s_bvalid | output | 1 | Wide write response valid |
| s_bready | input | 1 | Wide write response ready |
| s_bresp | output | 2 | Merged write response code |
| s_arvalid | input | 1 | Wide read address valid |
| s_arready | output | 1 | Wide read address ready |
| s_araddr | input | ADDR_W | Wide read byte address |
| s_rvalid | output | 1 | Wide read data valid |
| s_rready | input | 1 | Wide read data ready |
| s_rdata | output | WIDE_DW | Assembled wide read data |
| s_rresp | output | 2 | Merged read response code |
| m_awvalid | output | 1 | Narrow write address valid |
| m_awready | input | 1 | Narrow write address ready |
| m_awaddr | output | ADDR_W | Narrow write byte address |
| m_wvalid | output | 1 | Narrow write data valid |
| m_wready | input | 1 | Narrow write data ready |
| m_wdata | output | NARROW_DW | Narrow write data |
| m_wstrb | output | NARROW_DW/8 | Narrow byte enables |
| m_bvalid | input | 1 | Narrow write response valid |
| m_bready | output | 1 | Narrow write response ready |
| m_bresp | input | 2 | Narrow write response code |
| m_arvalid | output | 1 | Narrow read address valid |
| m_arready | input | 1 | Narrow read address ready |
| m_araddr | output | ADDR_W | Narrow read byte address |
| m_rvalid | input | 1 | Narrow read data valid |
| m_rready | output | 1 | Narrow read data ready |
| m_rdata | input | NARROW_DW | Narrow read data |
| m_rresp | input | 2 | Narrow read response code |

## Verification
The hardest cases to reach from the ports are response merging when one lane fails and another is skipped or also fails, and write data that arrives ahead of its address. The completer model in the bench answers chosen narrow addresses with SLVERR or DECERR. Wide accesses are placed so that the failing address falls in a sent lane, in a skipped lane, or in two lanes with different codes. The requester task can hold back the wide address for several cycles after offering the data, and meanwhile it watches that no narrow write appears. A mode that toggles the completer's ready signals every cycle forces the narrow address and data to be accepted in different cycles.

// File: rtl/axds_pkg.sv
`timescale 1ns/1ps
package axds_pkg;

  localparam logic [1:0] RESP_OK = 2'b00;

  typedef enum logic [1:0] {
    WR_GATHER,
    WR_SEND,
    WR_WAITB,
    WR_REPLY
  } wr_state_e;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_SEND,
    RD_WAITR,
    RD_REPLY
  } rd_state_e;

  // Keep the most severe code seen so far (larger value is worse).
  function automatic logic [1:0] merge_resp(input logic [1:0] acc, input logic [1:0] nxt);
    return (nxt > acc) ? nxt : acc;
  endfunction

endpackage

// File: rtl/axds_slice_pick.sv
`timescale 1ns/1ps
// Finds the lowest lane at or above 'from' whose live flag is set.
module axds_slice_pick #(
  parameter int LANES = 2,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] live,
  input  logic [IDX_W:0]   from,
  output logic             hit,
  output logic [IDX_W-1:0] pick
);

  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (live[i] && (i >= int'(from))) begin
        hit  = 1'b1;
        pick = i[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/axds_wr_path.sv
`timescale 1ns/1ps
module axds_wr_path
  import axds_pkg::*;
#(
  parameter int WIDE_DW   = 32,
  parameter int NARROW_DW = 16,
  parameter int ADDR_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s_awvalid,
  output logic                   s_awready,
  input  logic [ADDR_W-1:0]      s_awaddr,
  input  logic                   s_wvalid,
  output logic                   s_wready,
  input  logic [WIDE_DW-1:0]     s_wdata,
  input  logic [WIDE_DW/8-1:0]   s_wstrb,
  output logic                   s_bvalid,
  input  logic                   s_bready,
  output logic [1:0]             s_bresp,
  output logic                   m_awvalid,
  input  logic                   m_awready,
  output logic [ADDR_W-1:0]      m_awaddr,
  output logic                   m_wvalid,
  input  logic                   m_wready,
  output logic [NARROW_DW-1:0]   m_wdata,
  output logic [NARROW_DW/8-1:0] m_wstrb,
  input  logic                   m_bvalid,
  output logic                   m_bready,
  input  logic [1:0]             m_bresp
);

  localparam int RATIO   = WIDE_DW / NARROW_DW;
  localparam int NBN     = NARROW_DW / 8;
  localparam int NBW     = WIDE_DW / 8;
  localparam int IDX_W   = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int LANE_SH = $clog2(NBN);

  function automatic logic [ADDR_W-1:0] lane_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0]  k);
    return base + (ADDR_W'(k) << LANE_SH);
  endfunction

  function automatic logic [NARROW_DW-1:0] lane_data(input logic [WIDE_DW-1:0] d,
                                                     input logic [IDX_W-1:0]   k);
    return d[k*NARROW_DW +: NARROW_DW];
  endfunction

  function automatic logic [NBN-1:0] lane_strb(input logic [NBW-1:0]   s,
                                               input logic [IDX_W-1:0] k);
    return s[k*NBN +: NBN];
  endfunction

  wr_state_e             state_q;
  logic                  have_aw_q, have_w_q;
  logic                  aw_sent_q, w_sent_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [WIDE_DW-1:0]    data_q;
  logic [NBW-1:0]        strb_q;
  logic [IDX_W-1:0]      idx_q;
  logic [1:0]            resp_q;

  logic [RATIO-1:0]      live;
  logic [IDX_W:0]        from;
  logic                  hit;
  logic [IDX_W-1:0]      pick;
  logic                  aw_fire, w_fire, lane_out;

  for (genvar g = 0; g < RATIO; g++) begin : g_live
    assign live[g] = |strb_q[g*NBN +: NBN];
  end

  assign from = (state_q == WR_GATHER) ? '0 : ({1'b0, idx_q} + (IDX_W+1)'(1));

  axds_slice_pick #(.LANES(RATIO)) u_pick (
    .live (live),
    .from (from),
    .hit  (hit),
    .pick (pick)
  );

  assign s_awready = (state_q == WR_GATHER) && !have_aw_q;
  assign s_wready  = (state_q == WR_GATHER) && !have_w_q;
  assign m_awvalid = (state_q == WR_SEND) && !aw_sent_q;
  assign m_wvalid  = (state_q == WR_SEND) && !w_sent_q;
  assign m_awaddr  = lane_addr(addr_q, idx_q);
  assign m_wdata   = lane_data(data_q, idx_q);
  assign m_wstrb   = lane_strb(strb_q, idx_q);
  assign m_bready  = (state_q == WR_WAITB);
  assign s_bvalid  = (state_q == WR_REPLY);
  assign s_bresp   = resp_q;

  assign aw_fire  = m_awvalid && m_awready;
  assign w_fire   = m_wvalid && m_wready;
  assign lane_out = (aw_sent_q || aw_fire) && (w_sent_q || w_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WR_GATHER;
      have_aw_q <= 1'b0;
      have_w_q  <= 1'b0;
      aw_sent_q <= 1'b0;
      w_sent_q  <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      strb_q    <= '0;
      idx_q     <= '0;
      resp_q    <= RESP_OK;
    end else begin
      case (state_q)
        WR_GATHER: begin
          if (s_awvalid && s_awready) begin
            addr_q    <= s_awaddr;
            have_aw_q <= 1'b1;
          end
          if (s_wvalid && s_wready) begin
            data_q   <= s_wdata;
            strb_q   <= s_wstrb;
            have_w_q <= 1'b1;
          end
          if (have_aw_q && have_w_q) begin
            if (hit) begin
              idx_q   <= pick;
              state_q <= WR_SEND;
            end else begin
              state_q <= WR_REPLY;
            end
          end
        end
        WR_SEND: begin
          if (aw_fire) aw_sent_q <= 1'b1;
          if (w_fire)  w_sent_q  <= 1'b1;
          if (lane_out) begin
            aw_sent_q <= 1'b0;
            w_sent_q  <= 1'b0;
            state_q   <= WR_WAITB;
          end
        end
        WR_WAITB: begin
          if (m_bvalid) begin
            resp_q <= merge_resp(resp_q, m_bresp);
            if (hit) begin
              idx_q   <= pick;
              state_q <= WR_SEND;
            end else begin
              state_q <= WR_REPLY;
            end
          end
        end
        WR_REPLY: begin
          if (s_bready) begin
            have_aw_q <= 1'b0;
            have_w_q  <= 1'b0;
            resp_q    <= RESP_OK;
            state_q   <= WR_GATHER;
          end
        end
        default: state_q <= WR_GATHER;
      endcase
    end
  end

endmodule

// File: rtl/axds_rd_path.sv
`timescale 1ns/1ps
module axds_rd_path
  import axds_pkg::*;
#(
  parameter int WIDE_DW   = 32,
  parameter int NARROW_DW = 16,
  parameter int ADDR_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_arvalid,
  output logic                 s_arready,
  input  logic [ADDR_W-1:0]    s_araddr,
  output logic                 s_rvalid,
  input  logic                 s_rready,
  output logic [WIDE_DW-1:0]   s_rdata,
  output logic [1:0]           s_rresp,
  output logic                 m_arvalid,
  input  logic                 m_arready,
  output logic [ADDR_W-1:0]    m_araddr,
  input  logic                 m_rvalid,
  output logic                 m_rready,
  input  logic [NARROW_DW-1:0] m_rdata,
  input  logic [1:0]           m_rresp
);

  localparam int RATIO   = WIDE_DW / NARROW_DW;
  localparam int NBN     = NARROW_DW / 8;
  localparam int IDX_W   = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int LANE_SH = $clog2(NBN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RATIO - 1);

  function automatic logic [ADDR_W-1:0] lane_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0]  k);
    return base + (ADDR_W'(k) << LANE_SH);
  endfunction

  rd_state_e            state_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [IDX_W-1:0]     idx_q;
  logic [WIDE_DW-1:0]   gather_q;
  logic [1:0]           resp_q;

  assign s_arready = (state_q == RD_IDLE);
  assign m_arvalid = (state_q == RD_SEND);
  assign m_araddr  = lane_addr(addr_q, idx_q);
  assign m_rready  = (state_q == RD_WAITR);
  assign s_rvalid  = (state_q == RD_REPLY);
  assign s_rdata   = gather_q;
  assign s_rresp   = resp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RD_IDLE;
      addr_q   <= '0;
      idx_q    <= '0;
      gather_q <= '0;
      resp_q   <= RESP_OK;
    end else begin
      case (state_q)
        RD_IDLE: begin
          if (s_arvalid) begin
            addr_q  <= s_araddr;
            idx_q   <= '0;
            state_q <= RD_SEND;
          end
        end
        RD_SEND: begin
          if (m_arready) state_q <= RD_WAITR;
        end
        RD_WAITR: begin
          if (m_rvalid) begin
            gather_q[idx_q*NARROW_DW +: NARROW_DW] <= m_rdata;
            resp_q <= merge_resp(resp_q, m_rresp);
            if (idx_q == LAST) begin
              state_q <= RD_REPLY;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= RD_SEND;
            end
          end
        end
        RD_REPLY: begin
          if (s_rready) begin
            resp_q  <= RESP_OK;
            state_q <= RD_IDLE;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/axil_downsizer.sv
`timescale 1ns/1ps
module axil_downsizer #(
  parameter int WIDE_DW   = 32,
  parameter int NARROW_DW = 16,
  parameter int ADDR_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s_awvalid,
  output logic                   s_awready,
  input  logic [ADDR_W-1:0]      s_awaddr,
  input  logic                   s_wvalid,
  output logic                   s_wready,
  input  logic [WIDE_DW-1:0]     s_wdata,
  input  logic [WIDE_DW/8-1:0]   s_wstrb,
  output logic                   s_bvalid,
  input  logic                   s_bready,
  output logic [1:0]             s_bresp,
  input  logic                   s_arvalid,
  output logic                   s_arready,
  input  logic [ADDR_W-1:0]      s_araddr,
  output logic                   s_rvalid,
  input  logic                   s_rready,
  output logic [WIDE_DW-1:0]     s_rdata,
  output logic [1:0]             s_rresp,
  output logic                   m_awvalid,
  input  logic                   m_awready,
  output logic [ADDR_W-1:0]      m_awaddr,
  output logic                   m_wvalid,
  input  logic                   m_wready,
  output logic [NARROW_DW-1:0]   m_wdata,
  output logic [NARROW_DW/8-1:0] m_wstrb,
  input  logic                   m_bvalid,
  output logic                   m_bready,
  input  logic [1:0]             m_bresp,
  output logic                   m_arvalid,
  input  logic                   m_arready,
  output logic [ADDR_W-1:0]      m_araddr,
  input  logic                   m_rvalid,
  output logic                   m_rready,
  input  logic [NARROW_DW-1:0]   m_rdata,
  input  logic [1:0]             m_rresp
);

  axds_wr_path #(
    .WIDE_DW(WIDE_DW), .NARROW_DW(NARROW_DW), .ADDR_W(ADDR_W)
  ) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_awaddr  (s_awaddr),
    .s_wvalid  (s_wvalid),
    .s_wready  (s_wready),
    .s_wdata   (s_wdata),
    .s_wstrb   (s_wstrb),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_bresp   (s_bresp),
    .m_awvalid (m_awvalid),
    .m_awready (m_awready),
    .m_awaddr  (m_awaddr),
    .m_wvalid  (m_wvalid),
    .m_wready  (m_wready),
    .m_wdata   (m_wdata),
    .m_wstrb   (m_wstrb),
    .m_bvalid  (m_bvalid),
    .m_bready  (m_bready),
    .m_bresp   (m_bresp)
  );

  axds_rd_path #(
    .WIDE_DW(WIDE_DW), .NARROW_DW(NARROW_DW), .ADDR_W(ADDR_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_arvalid (s_arvalid),
    .s_arready (s_arready),
    .s_araddr  (s_araddr),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .s_rdata   (s_rdata),
    .s_rresp   (s_rresp),
    .m_arvalid (m_arvalid),
    .m_arready (m_arready),
    .m_araddr  (m_araddr),
    .m_rvalid  (m_rvalid),
    .m_rready  (m_rready),
    .m_rdata   (m_rdata),
    .m_rresp   (m_rresp)
  );

endmodule

// File: rtl/axds_checker.sv
`timescale 1ns/1ps
module axds_checker #(
  parameter int WIDE_DW   = 32,
  parameter int NARROW_DW = 16,
  parameter int ADDR_W    = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   s_awready,
  input logic                   s_wready,
  input logic                   s_bvalid,
  input logic                   s_bready,
  input logic                   s_arready,
  input logic                   s_rvalid,
  input logic                   s_rready,
  input logic                   m_awvalid,
  input logic                   m_awready,
  input logic [ADDR_W-1:0]      m_awaddr,
  input logic                   m_wvalid,
  input logic                   m_wready,
  input logic [NARROW_DW/8-1:0] m_wstrb,
  input logic                   m_bready,
  input logic                   m_arvalid,
  input logic                   m_arready,
  input logic [ADDR_W-1:0]      m_araddr,
  input logic                   m_rready
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(NARROW_DW / 8);

  logic              wr_open, rd_open;
  logic [ADDR_W-1:0] wr_prev, rd_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open <= 1'b0;
      rd_open <= 1'b0;
      wr_prev <= '0;
      rd_prev <= '0;
    end else begin
      if (m_awvalid && m_awready) begin
        wr_open <= 1'b1;
        wr_prev <= m_awaddr;
      end
      if (s_bvalid && s_bready) wr_open <= 1'b0;
      if (m_arvalid && m_arready) begin
        rd_open <= 1'b1;
        rd_prev <= m_araddr;
      end
      if (s_rvalid && s_rready) rd_open <= 1'b0;
    end
  end

  assert_rd_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && m_arready && rd_open) |-> (m_araddr == rd_prev + STEP));

  assert_wr_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && m_awready && wr_open) |-> (m_awaddr > wr_prev));

  assert_no_zero_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid |-> (m_wstrb != '0));

  assert_bresp_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> (!m_awvalid && !m_wvalid && !m_bready));

  assert_rresp_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> (!m_arvalid && !m_rready));

  assert_aw_w_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_awvalid) |-> $rose(m_wvalid));

  assert_one_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid || m_wvalid || m_bready || s_bvalid) |-> (!s_awready && !s_wready));

  assert_one_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid || m_rready || s_rvalid) |-> !s_arready);

  assert_hold_aw_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

  assert_hold_w_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wstrb)));

  assert_hold_ar_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

endmodule

bind axil_downsizer axds_checker #(
  .WIDE_DW(WIDE_DW), .NARROW_DW(NARROW_DW), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/sim_axil_downsizer.sv
`timescale 1ns/1ps
module sim_axil_downsizer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [31:0] s_awaddr = 0, s_wdata = 0, s_araddr = 0;
  logic [3:0]  s_wstrb = 0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
  logic [31:0] m_awaddr, m_araddr;
  logic [15:0] m_wdata;
  logic [1:0]  m_wstrb;
  logic        m_awready = 0, m_wready = 0, m_bvalid = 0, m_arready = 0, m_rvalid = 0;
  logic [1:0]  m_bresp = 0, m_rresp = 0;
  logic [15:0] m_rdata = 0;

  always #5 clk = ~clk;

  axil_downsizer u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit stall = 0;
  logic [31:0] err_slv = 32'hFFFF_FFF0, err_dec = 32'hFFFF_FFF0;
  logic [7:0]  smem   [256];
  logic [7:0]  shadow [256];
  logic [31:0] wlog_addr [16];
  logic [15:0] wlog_data [16];
  logic [1:0]  wlog_strb [16];
  logic [31:0] rlog_addr [16];
  int wlog_n = 0, rlog_n = 0, hold_chk = 0, hold_bad = 0;

  // addr[67:36], data[35:4], strobe[3:0]
  localparam logic [67:0] WVEC [8] = '{
    {32'h00, 32'h2222_1111, 4'b1111},
    {32'h04, 32'h4444_3333, 4'b1111},
    {32'h08, 32'h6666_5555, 4'b1011},
    {32'h10, 32'h8888_7777, 4'b1100},
    {32'h14, 32'hAAAA_9999, 4'b0011},
    {32'h18, 32'hCCCC_BBBB, 4'b0000},
    {32'h20, 32'hDEAD_BEEF, 4'b0110},
    {32'h24, 32'h0123_4567, 4'b1000}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] code_of(input logic [31:0] a);
    if (a == err_dec) return 2'b11;
    if (a == err_slv) return 2'b10;
    return 2'b00;
  endfunction

  // Narrow completer model: readies change at negedge, handshakes judged 1 ns later.
  initial begin : slave_model
    bit got_aw, got_w, got_ar, b_fire, r_fire, tog, prev_wait;
    logic [31:0] aw_a, ar_a, prev_a;
    logic [15:0] w_d;
    logic [1:0]  w_s;
    got_aw = 0; got_w = 0; got_ar = 0; b_fire = 0; r_fire = 0; tog = 0; prev_wait = 0;
    aw_a = 0; ar_a = 0; prev_a = 0; w_d = 0; w_s = 0;
    for (int i = 0; i < 256; i++) smem[i] = 8'(i * 7 + 3);
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        got_aw = 0; got_w = 0; got_ar = 0; b_fire = 0; r_fire = 0; prev_wait = 0;
        m_awready = 0; m_wready = 0; m_arready = 0; m_bvalid = 0; m_rvalid = 0;
      end else begin
        if (prev_wait) begin
          hold_chk++;
          if (!m_awvalid || m_awaddr != prev_a) hold_bad++;
        end
        if (b_fire) begin m_bvalid = 0; b_fire = 0; end
        if (r_fire) begin m_rvalid = 0; r_fire = 0; end
        if (got_aw && got_w && !m_bvalid) begin
          for (int b = 0; b < 2; b++)
            if (w_s[b]) smem[8'(aw_a + b)] = w_d[8*b +: 8];
          wlog_addr[wlog_n[3:0]] = aw_a;
          wlog_data[wlog_n[3:0]] = w_d;
          wlog_strb[wlog_n[3:0]] = w_s;
          wlog_n++;
          m_bresp = code_of(aw_a);
          m_bvalid = 1;
          got_aw = 0; got_w = 0;
        end
        if (got_ar && !m_rvalid) begin
          rlog_addr[rlog_n[3:0]] = ar_a;
          rlog_n++;
          m_rdata = {smem[8'(ar_a + 1)], smem[8'(ar_a)]};
          m_rresp = code_of(ar_a);
          m_rvalid = 1;
          got_ar = 0;
        end
        tog = !tog;
        m_awready = !got_aw && (!stall || tog);
        m_wready  = !got_w  && (!stall || !tog);
        m_arready = !got_ar && (!stall || tog);
        #1;
        prev_wait = m_awvalid && !m_awready;
        prev_a = m_awaddr;
        if (m_awvalid && m_awready) begin got_aw = 1; aw_a = m_awaddr; end
        if (m_wvalid && m_wready) begin got_w = 1; w_d = m_wdata; w_s = m_wstrb; end
        if (m_arvalid && m_arready) begin got_ar = 1; ar_a = m_araddr; end
        b_fire = m_bvalid && m_bready;
        r_fire = m_rvalid && m_rready;
      end
    end
  end

  task automatic wide_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                            input int lag, output logic [1:0] resp);
    bit aw_pend = 1, w_pend = 1, aw_hs, w_hs, first = 1;
    int wait_n = lag, early = 0;
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = s;
    s_wvalid = 1; s_awvalid = (lag == 0);
    while (aw_pend || w_pend) begin
      #1;
      aw_hs = s_awvalid && s_awready;
      w_hs  = s_wvalid && s_wready;
      if (aw_pend && m_awvalid) early++;
      @(negedge clk);
      if (aw_hs) begin s_awvalid = 0; aw_pend = 0; end
      if (w_hs)  begin s_wvalid = 0;  w_pend = 0;  end
      if (aw_pend && !s_awvalid) begin
        if (wait_n > 0) wait_n--;
        if (wait_n == 0) s_awvalid = 1;
      end
    end
    if (lag > 0) chk(early == 0, "R8", "narrow write before wide address", 64'(early), 0);
    s_bready = 1;
    forever begin
      #1;
      if (first) chk(!s_awready && !s_wready, "R9", "write readies while busy",
                     {s_awready, s_wready}, 0);
      first = 0;
      if (s_bvalid) begin
        resp = s_bresp;
        chk(!m_bvalid, "R7", "narrow B still pending at wide B", 64'(m_bvalid), 0);
        @(negedge clk);
        s_bready = 0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic wide_read(input logic [31:0] a, output logic [31:0] d, output logic [1:0] resp);
    bit first = 1;
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    forever begin
      #1;
      if (s_arready) begin @(negedge clk); s_arvalid = 0; break; end
      @(negedge clk);
    end
    s_rready = 1;
    forever begin
      #1;
      if (first) chk(!s_arready, "R9", "read ready while busy", 64'(s_arready), 0);
      first = 0;
      if (s_rvalid) begin
        d = s_rdata; resp = s_rresp;
        chk(!m_rvalid, "R7", "narrow R still pending at wide R", 64'(m_rvalid), 0);
        @(negedge clk);
        s_rready = 0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic write_check(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                             input int lag, input logic [1:0] exp_resp);
    logic [1:0] resp;
    int en = 0;
    wlog_n = 0;
    wide_write(a, d, s, lag, resp);
    for (int k = 0; k < 2; k++) begin
      if (s[2*k +: 2] != 2'b00) begin
        if (en < wlog_n) begin
          chk(wlog_addr[en] == a + 32'(2*k), "R2", "narrow write address", wlog_addr[en], a + 32'(2*k));
          chk(wlog_data[en] == d[16*k +: 16], "R3", "narrow write data", wlog_data[en], d[16*k +: 16]);
          chk(wlog_strb[en] == s[2*k +: 2], "R3", "narrow write strobe", wlog_strb[en], s[2*k +: 2]);
        end
        en++;
      end
    end
    chk(wlog_n == en, "R4", "narrow write count (R1 bound)", 64'(wlog_n), 64'(en));
    chk(resp == exp_resp, "R6", "wide write response", resp, exp_resp);
    for (int b = 0; b < 4; b++)
      if (s[b]) shadow[8'(a + b)] = d[8*b +: 8];
  endtask

  task automatic read_check(input logic [31:0] a, input logic [1:0] exp_resp);
    logic [31:0] d, e;
    logic [1:0]  resp;
    rlog_n = 0;
    wide_read(a, d, resp);
    e = {shadow[8'(a + 3)], shadow[8'(a + 2)], shadow[8'(a + 1)], shadow[8'(a)]};
    chk(d == e, "R5", "assembled read data", d, e);
    chk(resp == exp_resp, "R6", "wide read response", resp, exp_resp);
    chk(rlog_n == 2, "R1", "narrow read count", 64'(rlog_n), 2);
    chk(rlog_addr[0] == a && rlog_addr[1] == a + 2, "R2", "narrow read order",
        {rlog_addr[0], rlog_addr[1]}, {a, a + 32'd2});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    #1;
    chk({s_bvalid, s_rvalid, m_awvalid, m_wvalid, m_arvalid} == 5'b0, "R10",
        "valid outputs in reset", {s_bvalid, s_rvalid, m_awvalid, m_wvalid, m_arvalid}, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 8; v++)
      write_check(WVEC[v][67:36], WVEC[v][35:4], WVEC[v][3:0], 0, 2'b00);
    for (int v = 0; v < 8; v++)
      read_check(WVEC[v][67:36], 2'b00);

    // R4: all-zero strobe, memory must stay unchanged
    write_check(32'h70, 32'hFFFF_FFFF, 4'b0000, 0, 2'b00);
    read_check(32'h70, 2'b00);

    // R8: write data offered three cycles before its address
    write_check(32'h74, 32'h5A5A_A5A5, 4'b0111, 3, 2'b00);
    read_check(32'h74, 2'b00);

    // R11: completer readies toggle, address and data accepted apart
    stall = 1;
    write_check(32'h30, 32'hFACE_B00C, 4'b1111, 0, 2'b00);
    write_check(32'h34, 32'h1357_9BDF, 4'b1001, 2, 2'b00);
    read_check(32'h30, 2'b00);
    read_check(32'h34, 2'b00);
    stall = 0;
    chk(hold_chk > 0 && hold_bad == 0, "R11", "narrow address hold", 64'(hold_bad), 0);

    // R6: error in upper lane, both lanes still sent
    err_slv = 32'h42;
    write_check(32'h40, 32'h2468_1357, 4'b1111, 0, 2'b10);
    read_check(32'h40, 2'b10);
    // R6: error address sits in a skipped lane
    err_dec = 32'h50;
    write_check(32'h50, 32'h9999_8888, 4'b1100, 0, 2'b00);
    // R6: two lanes with different codes, the larger wins
    err_slv = 32'h60;
    err_dec = 32'h62;
    read_check(32'h60, 2'b11);
    write_check(32'h60, 32'h7777_6666, 4'b1111, 0, 2'b11);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule